// File: doc/BRIEF.md
# MDIO Management Master

This block runs clause-22 management transactions against an external PHY. The block has one request port. A single-cycle request carries a read/write flag, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The block then produces the complete serial frame: the management clock, the data output and its output enable. For reads it also samples the data input.

Every frame starts with a run of one bits that synchronises the PHY. A read then sends start and opcode fields and the two addresses, and lets go of the line for nineteen bit times. Over that window it collects turnaround, data and idle bits, and it keeps the sixteen data bits from the middle of the window. A write sends a single 32-bit command word, which ends with the turnaround pattern and the data. Two more clocks follow with the line released.

The parameter `HALF_CYCLES` sets the management clock half-period in system clocks. The default of 25 gives 2.5 MHz from a 125 MHz clock. The block holds `busy` for the length of a frame and pulses `done` when the frame is over. It also flags reads of the status register that show no PHY at the address.

Top module: `mdio_master`

## Requirements
- R1: While reset is held, and right after it, `mdc`, `mdoEn`, `mdoOut`, `busy`, `done`, `noPhy` and `rdData` are all zero.
- R2: A request sampled with `reqValid` high while `busy` is low is accepted. Its first 32 bit slots carry `mdoOut`=1 with `mdoEn`=1.
- R3: A read sends, after the preamble, the 14 bits 0,1,1,0, then PHY address bits 4..0, then register address bits 4..0, each with `mdoEn`=1 (slots 32..45).
- R4: After the header, a read holds `mdoEn`=0 and `mdoOut`=0 for 19 slots (46..64). `rdData` takes the input bits sampled in slots 48..63, with the first of these as bit 15. The frame is 65 slots.
- R5: A write sends, after the preamble, 32 driven bits: 0,1,0,1, PHY address bits 4..0, register address bits 4..0, then 1,0, then write data bits 15..0 (slots 32..63). Two released slots follow (64..65). The frame is 66 slots.
- R6: Each bit slot lasts `HALF_CYCLES` clocks with `mdc` low, then `HALF_CYCLES` clocks with `mdc` high. Slot 0 starts in the cycle after the accepting edge. `mdoOut` and `mdoEn` change only at slot starts, while `mdc` is low.
- R7: `mdiIn` is sampled at the clock edge on which `mdc` goes high, so the value it has in the last low cycle of the slot is the one used.
- R8: `busy` is high from slot 0 through the last high cycle. In the cycle after that, `done` is high for exactly one cycle and `busy` is low, and a new request can be accepted in that same cycle.
- R9: `reqValid` has no effect while `busy` is high. The frame in progress is unchanged and no extra frame or `done` follows.
- R10: When a read of register address 1 returns 0xFFFF or 0x0000, `noPhy` is 1 from its `done` cycle on. Any other completed transaction clears `noPhy`. A write leaves `rdData` unchanged.
- R11: While no frame is running, `mdc`, `mdoEn` and `mdoOut` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken when not busy |
| reqWrite | input | 1 | 1 = write transaction, 0 = read |
| reqPhy | input | 5 | PHY address |
| reqReg | input | 5 | Register address within the PHY |
| reqWdata | input | 16 | Data for a write |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rdData | output | 16 | Data from the last completed read |
| noPhy | output | 1 | Last read of register 1 returned all ones or all zeros |
| mdc | output | 1 | Management clock |
| mdoOut | output | 1 | Management data output |
| mdoEn | output | 1 | Output enable for the data line |
| mdiIn | input | 1 | Management data input |

## Verification
Let the request be accepted at edge E, with half-period H. Slot s then fills cycles 2Hs+1 to 2Hs+2H after E, with `mdc` low for the first H of them. `done`, together with the new `rdData` and `noPhy`, is due in cycle 2HN+1, where N is 65 for a read and 66 for a write. The bench model expands each request into one expected entry per clock and pops one entry 2 ns after every rising edge. It compares every output at that moment and drives `mdiIn` from the same entry. The model drives the correct input bit only in the last low cycle of each slot and its inverse in every other cycle, so a capture on any other edge produces wrong read data.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int ADDR_W   = 5;
  localparam int DATA_W   = 16;

  // frame geometry in bit slots
  localparam int PRE_LEN  = 32;
  localparam int HDR_LEN  = 4 + 2 * ADDR_W;           // start, opcode, two addresses
  localparam int RD_TAIL  = 2 + DATA_W + 1;           // turnaround, data, idle
  localparam int WR_WORD  = HDR_LEN + 2 + DATA_W;     // whole write command word
  localparam int WR_TAIL  = 2;
  localparam int RD_SLOTS = PRE_LEN + HDR_LEN + RD_TAIL;
  localparam int WR_SLOTS = PRE_LEN + WR_WORD + WR_TAIL;
  localparam int RD_DRIVE = PRE_LEN + HDR_LEN;        // first released slot of a read
  localparam int WR_DRIVE = PRE_LEN + WR_WORD;        // first released slot of a write
  localparam int SLOT_W   = $clog2(WR_SLOTS + 1);
  localparam int OUT_W    = PRE_LEN + WR_WORD;
  localparam int CAP_W    = RD_TAIL;

  localparam logic [1:0] FLD_START = 2'b01;
  localparam logic [1:0] FLD_OP_RD = 2'b10;
  localparam logic [1:0] FLD_OP_WR = 2'b01;
  localparam logic [1:0] FLD_TURN  = 2'b10;

  localparam logic [ADDR_W-1:0] STATUS_REG = ADDR_W'(1);

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // request accepted this edge
    logic shift;    // advance to next output bit
    logic capture;  // sample input bit
    logic finish;   // frame complete
  } dpStrobe_t;

endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int HALF_CYCLES = 25
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqWrite,
  output logic      busy,
  output logic      done,
  output logic      mdc,
  output logic      drvEn,
  output dpStrobe_t strb
);

  localparam int DIV_W = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
  localparam logic [DIV_W-1:0]  DIV_LAST  = DIV_W'(HALF_CYCLES - 1);
  localparam logic [SLOT_W-1:0] RD_LAST   = SLOT_W'(RD_SLOTS - 1);
  localparam logic [SLOT_W-1:0] WR_LAST   = SLOT_W'(WR_SLOTS - 1);
  localparam logic [SLOT_W-1:0] RD_REL    = SLOT_W'(RD_DRIVE);
  localparam logic [SLOT_W-1:0] WR_REL    = SLOT_W'(WR_DRIVE);

  typedef enum logic {ST_IDLE, ST_RUN} state_t;

  state_t            state;
  logic [DIV_W-1:0]  divCnt;
  logic              phaseHigh;
  logic [SLOT_W-1:0] slot;
  logic              wrQ;

  logic running;
  logic tick;
  logic lastSlot;
  logic [SLOT_W-1:0] relSlot;

  always_comb begin
    running       = (state == ST_RUN);
    tick          = running && (divCnt == DIV_LAST);
    lastSlot      = (slot == (wrQ ? WR_LAST : RD_LAST));
    relSlot       = wrQ ? WR_REL : RD_REL;
    strb.load     = (state == ST_IDLE) && reqValid;
    strb.capture  = tick && !phaseHigh && !wrQ && (slot >= RD_REL);
    strb.shift    = tick && phaseHigh && !lastSlot;
    strb.finish   = tick && phaseHigh && lastSlot;
    busy          = running;
    mdc           = running && phaseHigh;
    drvEn         = running && (slot < relSlot);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      divCnt    <= '0;
      phaseHigh <= 1'b0;
      slot      <= '0;
      wrQ       <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (reqValid) begin
            state     <= ST_RUN;
            divCnt    <= '0;
            phaseHigh <= 1'b0;
            slot      <= '0;
            wrQ       <= reqWrite;
          end
        end
        ST_RUN: begin
          if (tick) begin
            divCnt <= '0;
            if (!phaseHigh) begin
              phaseHigh <= 1'b1;
            end else begin
              phaseHigh <= 1'b0;
              if (lastSlot) begin
                state <= ST_IDLE;
                done  <= 1'b1;
              end else begin
                slot <= slot + 1'b1;
              end
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  busy_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R9
  accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(reqValid));

endmodule

// File: rtl/mdio_dp.sv
module mdio_dp
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic              drvEn,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqPhy,
  input  logic [ADDR_W-1:0] reqReg,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              mdiIn,
  output logic              mdoOut,
  output logic [DATA_W-1:0] rdData,
  output logic              noPhy
);

  logic [OUT_W-1:0]  outSr;
  logic [CAP_W-1:0]  inSr;
  logic [ADDR_W-1:0] regQ;
  logic              wrQ;
  logic [WR_WORD-1:0] cmdWord;
  logic [DATA_W-1:0] capData;

  always_comb begin
    if (reqWrite)
      cmdWord = {FLD_START, FLD_OP_WR, reqPhy, reqReg, FLD_TURN, reqWdata};
    else
      cmdWord = {FLD_START, FLD_OP_RD, reqPhy, reqReg, {(WR_WORD - HDR_LEN){1'b0}}};
    capData = inSr[DATA_W:1];
    mdoOut  = drvEn & outSr[OUT_W-1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outSr  <= '0;
      inSr   <= '0;
      regQ   <= '0;
      wrQ    <= 1'b0;
      rdData <= '0;
      noPhy  <= 1'b0;
    end else begin
      if (strb.load) begin
        outSr <= {{PRE_LEN{1'b1}}, cmdWord};
        inSr  <= '0;
        regQ  <= reqReg;
        wrQ   <= reqWrite;
      end else begin
        if (strb.shift)
          outSr <= {outSr[OUT_W-2:0], 1'b0};
        if (strb.capture)
          inSr <= {inSr[CAP_W-2:0], mdiIn};
      end
      if (strb.finish) begin
        if (wrQ) begin
          noPhy <= 1'b0;
        end else begin
          rdData <= capData;
          noPhy  <= (regQ == STATUS_REG) && ((&capData) || !(|capData));
        end
      end
    end
  end

  // R4
  capture_released_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |-> !drvEn);

  // R2
  preamble_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (drvEn && mdoOut));

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.finish) |-> ($stable(noPhy) && $stable(rdData)));

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int HALF_CYCLES = 25
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [4:0]  reqPhy,
  input  logic [4:0]  reqReg,
  input  logic [15:0] reqWdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] rdData,
  output logic        noPhy,
  output logic        mdc,
  output logic        mdoOut,
  output logic        mdoEn,
  input  logic        mdiIn
);

  dpStrobe_t strb;
  logic      drvEn;

  mdio_ctrl #(.HALF_CYCLES(HALF_CYCLES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .busy     (busy),
    .done     (done),
    .mdc      (mdc),
    .drvEn    (drvEn),
    .strb     (strb)
  );

  mdio_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .drvEn    (drvEn),
    .reqWrite (reqWrite),
    .reqPhy   (reqPhy),
    .reqReg   (reqReg),
    .reqWdata (reqWdata),
    .mdiIn    (mdiIn),
    .mdoOut   (mdoOut),
    .rdData   (rdData),
    .noPhy    (noPhy)
  );

  assign mdoEn = drvEn;

  // R6
  edge_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mdc) |-> ($stable(mdoOut) && $stable(mdoEn)));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!mdoOut && !mdc));

endmodule

// File: tb/tb_mdio_master.sv
`timescale 1ns/1ps
module tb_mdio_master;

  localparam int H = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [4:0]  reqPhy = '0;
  logic [4:0]  reqReg = '0;
  logic [15:0] reqWdata = '0;
  logic        busy, done, noPhy, mdc, mdoOut, mdoEn;
  logic [15:0] rdData;
  logic        mdiIn = 1'b0;

  mdio_master #(.HALF_CYCLES(H)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqPhy(reqPhy), .reqReg(reqReg), .reqWdata(reqWdata),
    .busy(busy), .done(done), .rdData(rdData), .noPhy(noPhy),
    .mdc(mdc), .mdoOut(mdoOut), .mdoEn(mdoEn), .mdiIn(mdiIn)
  );

  always #4 clk = ~clk;   // 125 MHz

  typedef struct packed {
    logic        mdi;
    logic        busy;
    logic        done;
    logic        mdc;
    logic        oe;
    logic        mdo;
    logic        noPhy;
    logic [15:0] rd;
    logic [3:0]  tag;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  int   tests = 0;
  int   fails = 0;
  int   cycles = 0;
  bit   chkOn = 1'b0;
  logic [15:0] holdRd = '0;
  logic        holdNo = 1'b0;
  logic [15:0] mRd = '0;
  logic        mNo = 1'b0;
  logic [3:0]  idleTag = 4'd11;

  function automatic string tagName(input logic [3:0] t);
    case (t)
      4'd1:  return "R1";
      4'd2:  return "R2";
      4'd3:  return "R3";
      4'd4:  return "R4";
      4'd5:  return "R5";
      4'd6:  return "R6";
      4'd7:  return "R7";
      4'd8:  return "R8";
      4'd9:  return "R9";
      4'd10: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // per-clock comparison against the reference model
  always @(posedge clk) begin
    cycles++;
    #2;
    if (chkOn) begin
      if (q.size() > 0) cur = q.pop_front();
      else cur = '{mdi: 1'b0, busy: 1'b0, done: 1'b0, mdc: 1'b0, oe: 1'b0,
                   mdo: 1'b0, noPhy: holdNo, rd: holdRd, tag: idleTag};
      chk(cur.tag == 4'd11 ? "R11" : "R6", "mdc", {31'd0, mdc}, {31'd0, cur.mdc});
      chk(tagName(cur.tag), "mdoEn", {31'd0, mdoEn}, {31'd0, cur.oe});
      chk(tagName(cur.tag), "mdoOut", {31'd0, mdoOut}, {31'd0, cur.mdo});
      chk(cur.tag == 4'd9 ? "R9" : "R8", "busy", {31'd0, busy}, {31'd0, cur.busy});
      chk(cur.tag == 4'd9 ? "R9" : "R8", "done", {31'd0, done}, {31'd0, cur.done});
      chk("R4 R7", "rdData", {16'd0, rdData}, {16'd0, cur.rd});
      chk("R10", "noPhy", {31'd0, noPhy}, {31'd0, cur.noPhy});
      holdRd = cur.rd;
      holdNo = cur.noPhy;
      mdiIn  = cur.mdi;
    end
  end

  // queue one transaction and its expected per-clock trace
  task automatic runTxn(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                        input logic [15:0] wd, input logic [15:0] pd,
                        input logic [3:0] ovr, input int spam);
    logic [63:0] frame;
    logic [15:0] prevRd;
    logic        prevNo;
    exp_t e;
    int n, drv;
    while (q.size() != 0) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqPhy = phy; reqReg = rg; reqWdata = wd;
    frame = wr ? {32'hFFFF_FFFF, 2'b01, 2'b01, phy, rg, 2'b10, wd}
               : {32'hFFFF_FFFF, 2'b01, 2'b10, phy, rg, 18'h0};
    n   = wr ? 66 : 65;
    drv = wr ? 64 : 46;
    prevRd = mRd; prevNo = mNo;
    for (int s = 0; s < n; s++) begin
      logic bitv, inb;
      logic [3:0] t;
      bitv = (s < drv) ? frame[63 - s] : 1'b0;
      if (s < 32) t = 4'd2;
      else if (s < drv) t = wr ? 4'd5 : 4'd3;
      else t = wr ? 4'd5 : 4'd4;
      if (ovr != 4'd0) t = ovr;
      inb = 1'b0;
      if (!wr && s >= 48 && s <= 63) inb = pd[63 - s];
      else if (!wr && (s == 46 || s == 64)) inb = 1'b1;
      for (int c = 0; c < 2 * H; c++) begin
        e.mdi   = (c == H - 1) ? inb : ~inb;   // R7: valid only before the rise
        e.busy  = 1'b1;
        e.done  = 1'b0;
        e.mdc   = (c >= H);
        e.oe    = (s < drv);
        e.mdo   = bitv;
        e.noPhy = prevNo;
        e.rd    = prevRd;
        e.tag   = t;
        q.push_back(e);
      end
    end
    if (!wr) begin
      mRd = pd;
      mNo = (rg == 5'd1) && (pd == 16'hFFFF || pd == 16'h0000);
    end else begin
      mNo = 1'b0;
    end
    e = '{mdi: 1'b0, busy: 1'b0, done: 1'b1, mdc: 1'b0, oe: 1'b0, mdo: 1'b0,
          noPhy: mNo, rd: mRd, tag: (ovr != 4'd0) ? ovr : 4'd8};
    q.push_back(e);
    @(negedge clk);
    if (spam > 0) begin
      // R9: requests while busy must be ignored
      reqValid = 1'b1; reqWrite = ~wr; reqPhy = ~phy; reqReg = ~rg; reqWdata = ~wd;
      repeat (spam) @(negedge clk);
    end
    reqValid = 1'b0;
  endtask

  // watchdog
  initial begin
    wait (cycles > 150000);
    fails++;
    $display("FAIL R8 watchdog actual=hung expected=completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    repeat (5) @(negedge clk);
    // R1: state under reset
    chk("R1", "busy", {31'd0, busy}, 32'd0);
    chk("R1", "mdc", {31'd0, mdc}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    // R1: state after reset
    chk("R1", "busy", {31'd0, busy}, 32'd0);
    chk("R1", "done", {31'd0, done}, 32'd0);
    chk("R1", "mdc", {31'd0, mdc}, 32'd0);
    chk("R1", "mdoEn", {31'd0, mdoEn}, 32'd0);
    chk("R1", "mdoOut", {31'd0, mdoOut}, 32'd0);
    chk("R1", "rdData", {16'd0, rdData}, 32'd0);
    chk("R1", "noPhy", {31'd0, noPhy}, 32'd0);
    chkOn = 1'b1;
    repeat (3) @(negedge clk);

    // R3 R4 R7: plain read
    runTxn(1'b0, 5'h11, 5'h02, 16'h0000, 16'hA5C3, 4'd0, 0);
    // R5 R10: write keeps rdData
    runTxn(1'b1, 5'h1F, 5'h1E, 16'h8001, 16'h0000, 4'd0, 0);
    // R10: status register reads
    runTxn(1'b0, 5'h03, 5'h01, 16'h0000, 16'hFFFF, 4'd0, 0);
    runTxn(1'b0, 5'h04, 5'h01, 16'h0000, 16'h1234, 4'd0, 0);
    runTxn(1'b0, 5'h00, 5'h01, 16'h0000, 16'h0000, 4'd0, 0);
    runTxn(1'b0, 5'h0A, 5'h02, 16'h0000, 16'hFFFF, 4'd0, 0);
    runTxn(1'b0, 5'h15, 5'h01, 16'h0000, 16'h0000, 4'd0, 0);
    // R10: write clears the flag; R9: requests during the frame ignored
    runTxn(1'b1, 5'h0A, 5'h15, 16'h5A3C, 16'h0000, 4'd9, 20);
    // R9: read with requests held during it
    runTxn(1'b0, 5'h1E, 5'h1F, 16'h0000, 16'h7E81, 4'd9, 30);
    // R8: back-to-back frames accepted in the done cycle
    runTxn(1'b1, 5'h01, 5'h00, 16'hFFFF, 16'h0000, 4'd0, 0);
    runTxn(1'b0, 5'h1F, 5'h1F, 16'h0000, 16'h8000, 4'd0, 0);

    while (q.size() != 0) @(negedge clk);
    idleTag = 4'd11;
    repeat (4 * H) @(negedge clk);   // R11: stays idle
    chkOn = 1'b0;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule